// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent page translations so that a virtual address can be turned into a physical address without walking the page table. Each entry pairs a 20-bit virtual page number (the tag) with a 20-bit physical frame number (the data) and has a valid bit. A lookup compares the upper bits of the incoming virtual address against every valid entry at once. It returns a hit flag and the physical address in the same cycle. The 12-bit page offset passes straight through and is placed below the stored frame number.

After a miss, the surrounding logic walks the page table and installs the result through the refill port. A refill takes a free entry if one exists. When the array is full, it replaces the entry that has gone unused longest. Recency is kept as a per-entry age that forms a permutation of 0..ENTRIES-1. The entry just used gets age 0, and every entry that was younger than it ages by one. A single flush input drops every translation at once.

Top module: `tlb_fa`

## Requirements
- R1: After reset, and on the clock edge after `flush` is high, every entry is empty: every lookup misses until a refill installs a translation.
- R2: `lk_hit` is high in the same cycle as the lookup when `lk_valid` is high and a valid entry's tag equals `lk_vaddr[31:12]`.
- R3: On a hit, `lk_paddr` equals the entry's frame number in bits 31:12 with `lk_vaddr[11:0]` unchanged in bits 11:0. On a miss, `lk_paddr` is zero.
- R4: When `lk_valid` is low, `lk_hit` stays low and `lk_paddr` is zero, even if the address matches a stored tag.
- R5: While any entry is empty, a refill with a new tag evicts nothing. After a flush, ENTRIES refills with distinct tags leave all of them resident.
- R6: When all entries are valid, a refill with a new tag replaces the least recently used entry. Both a refill and a lookup hit count as a use.
- R7: A lookup hit in a cycle with no refill and no flush makes that entry the most recently used from the next clock edge onward.
- R8: A refill whose tag is already resident overwrites that entry's frame number in place. No duplicate is created and no other entry is lost.
- R9: When `flush` and `fill_en` are high in the same cycle, the flush wins and the refill has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate every entry at the next edge |
| lk_valid | input | 1 | Lookup request qualifier |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found (combinational) |
| lk_paddr | output | 32 | Translated physical address, zero on miss |
| fill_en | input | 1 | Install a translation at the next edge |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number to install |

## Verification
The hardest case to reach is an eviction whose victim depends on a recency order shaped by both refills and lookup hits. For example, an entry that was refilled early but touched by a later hit must survive, while the next-oldest entry goes. The stimulus first fills the array and then touches entries in a chosen order. It then refills new tags and probes every old tag, so that the victim shows up as the single miss. A bench model keeps its own most-recent-first list and predicts every lookup outcome.

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_vaddr,
  output logic                  lk_hit,
  output logic [PA_W-1:0]       lk_paddr,
  input  logic                  fill_en,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_pfn
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]            valid, lk_match, fill_match;
  logic [ENTRIES-1:0][VPN_W-1:0] tag;
  logic [ENTRIES-1:0][PFN_W-1:0] frame;
  logic [ENTRIES-1:0][IDX_W-1:0] age;
  logic [VPN_W-1:0]              lk_vpn;
  logic [IDX_W-1:0]              hit_idx, fill_idx, touch_idx;
  logic                          touch_en;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g]   = valid[g] && (tag[g] == lk_vpn);
    assign fill_match[g] = valid[g] && (tag[g] == fill_vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) hit_idx = IDX_W'(i);
  end

  always_comb begin
    fill_idx = '0;
    if (|fill_match) begin
      for (int i = 0; i < ENTRIES; i++)
        if (fill_match[i]) fill_idx = IDX_W'(i);
    end else if (!(&valid)) begin
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!valid[i]) fill_idx = IDX_W'(i);
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (age[i] == OLDEST) fill_idx = IDX_W'(i);
    end
  end

  assign lk_hit    = lk_valid && (|lk_match);
  assign lk_paddr  = lk_hit ? {frame[hit_idx], lk_vaddr[OFF_W-1:0]} : '0;
  assign touch_en  = !flush && (fill_en || lk_hit);
  assign touch_idx = fill_en ? fill_idx : hit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid <= '0;
      for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
    end else begin
      if (fill_en) begin
        valid[fill_idx] <= 1'b1;
        tag[fill_idx]   <= fill_vpn;
        frame[fill_idx] <= fill_pfn;
      end
      if (touch_en) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == touch_idx)        age[i] <= '0;
          else if (age[i] < age[touch_idx])  age[i] <= age[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          flush,
  input logic                          lk_valid,
  input logic [VA_W-1:0]               lk_vaddr,
  input logic                          lk_hit,
  input logic [PA_W-1:0]               lk_paddr,
  input logic                          fill_en,
  input logic [VA_W-OFF_W-1:0]         fill_vpn,
  input logic [PA_W-OFF_W-1:0]         fill_pfn,
  input logic [ENTRIES-1:0]            valid,
  input logic [ENTRIES-1:0]            lk_match,
  input logic [ENTRIES-1:0][IDX_W-1:0] age
);
  logic [ENTRIES-1:0] is_oldest;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign is_oldest[g] = (age[g] == IDX_W'(ENTRIES - 1));
  end

  p_flush_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> (valid == '0));

  p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == '0));

  p_idle_no_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit);

  p_single_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_oldest) == 1);

  p_no_duplicate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  p_fill_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_en && !flush) && lk_valid && (lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)))
      |-> (lk_hit && (lk_paddr[PA_W-1:OFF_W] == $past(fill_pfn))));

  p_flush_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush && fill_en) |-> !lk_hit);
endmodule

bind tlb_fa tlb_fa_chk #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_paddr(lk_paddr), .fill_en(fill_en), .fill_vpn(fill_vpn),
  .fill_pfn(fill_pfn), .valid(valid), .lk_match(lk_match), .age(age)
);

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;

  always #4 clk = ~clk;

  tlb_fa u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn)
  );

  typedef struct {
    logic        hit;
    logic [31:0] pa;
    string       req;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        m_val [N];
  logic [19:0] m_vpn [N];
  logic [19:0] m_pfn [N];
  int          m_order[$];

  task automatic m_touch(int idx);
    foreach (m_order[k]) if (m_order[k] == idx) begin m_order.delete(k); break; end
    m_order.push_front(idx);
  endtask

  task automatic m_clear();
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
    m_order.delete();
    for (int i = 0; i < N; i++) m_order.push_back(i);
  endtask

  task automatic look(input logic [31:0] va, input logic req_v, input string req);
    exp_t e;
    int hi;
    hi = -1;
    for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == va[31:12]) hi = i;
    e.hit = req_v && (hi >= 0);
    e.pa  = e.hit ? {m_pfn[hi], va[11:0]} : 32'h0;
    e.req = req;
    if (e.hit) m_touch(hi);
    lk_valid = req_v;
    lk_vaddr = va;
    sb_q.push_back(e);
    @(posedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic with_flush);
    int idx;
    idx = -1;
    if (with_flush) m_clear();
    else begin
      for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == vpn) idx = i;
      if (idx < 0) for (int i = N - 1; i >= 0; i--) if (!m_val[i]) idx = i;
      if (idx < 0) idx = m_order[$];
      m_val[idx] = 1'b1; m_vpn[idx] = vpn; m_pfn[idx] = pfn;
      m_touch(idx);
    end
    fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; flush = with_flush;
    @(posedge clk); #1;
    fill_en = 1'b0; flush = 1'b0;
  endtask

  task automatic do_flush();
    m_clear();
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (lk_hit !== e.hit || lk_paddr !== e.pa) begin
        errors++;
        $display("FAIL %s: hit=%0b pa=%h expected hit=%0b pa=%h", e.req, lk_hit, lk_paddr, e.hit, e.pa);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    look(32'h1234_5678, 1'b1, "R1 reset empty");
    look(32'h0000_0000, 1'b1, "R1 reset empty zero addr");

    for (int i = 0; i < N; i++) fill(20'h10000 + 20'(i), 20'h80000 + 20'(i * 3), 1'b0);
    for (int i = 0; i < N; i++) look({20'h10000 + 20'(i), 12'(i * 291)}, 1'b1, "R2 R3 R5 hit after fill");
    look({20'h10002, 12'hfff}, 1'b1, "R3 offset all ones");
    look({20'h3abcd, 12'h001}, 1'b1, "R3 miss gives zero");
    look({20'h10004, 12'h100}, 1'b0, "R4 idle lookup no hit");

    look({20'h10000, 12'h0}, 1'b1, "R7 touch entry");
    look({20'h10001, 12'h0}, 1'b1, "R7 touch entry");
    fill(20'h20000, 20'h0aaaa, 1'b0);
    for (int i = 0; i < N; i++) look({20'h10000 + 20'(i), 12'h010}, 1'b1, "R6 R7 victim probe");
    look({20'h20000, 12'h020}, 1'b1, "R6 new entry resident");
    fill(20'h20001, 20'h0bbbb, 1'b0);
    for (int i = 0; i < N; i++) look({20'h10000 + 20'(i), 12'h030}, 1'b1, "R6 second victim probe");

    fill(20'h10005, 20'h0cccc, 1'b0);
    look({20'h10005, 12'h444}, 1'b1, "R8 overwrite in place");
    for (int i = 0; i < N; i++) look({20'h10000 + 20'(i), 12'h050}, 1'b1, "R8 no entry lost");
    look({20'h20000, 12'h0}, 1'b1, "R8 no entry lost");
    look({20'h20001, 12'h0}, 1'b1, "R8 no entry lost");

    fill(20'h30000, 20'h0dddd, 1'b1);
    look({20'h30000, 12'h0}, 1'b1, "R9 flush beats refill");
    look({20'h10005, 12'h0}, 1'b1, "R1 flush empties");

    for (int i = 0; i < N; i++) fill(20'h40000 + 20'(i * 7), 20'h50000 + 20'(i), 1'b0);
    for (int i = N - 1; i >= 0; i--) look({20'h40000 + 20'(i * 7), 12'h0ab}, 1'b1, "R5 all resident after flush");

    do_flush();
    fill(20'h60000, 20'h61000, 1'b0);
    look({20'h60000, 12'h1}, 1'b1, "R5 single fill after flush");
    look({20'h40000, 12'h1}, 1'b1, "R1 old entries gone");

    @(posedge clk); #1;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule